// File: doc/BRIEF.md
# Sequenced Shared-Line Driver

This block drives a group of lanes that several agents share in a wired-OR arrangement. The system guarantees that no two agents drive at the same time, so there is no arbitration here. The lanes need no strong pull resistor. On an accepted request the block drives the requested value for a programmable number of clocks. It then actively drives the idle level for exactly one clock and releases the lanes (output enable low). After release a weak pull or keeper holds the idle level.

Requests arrive on a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the lanes are released, so it also serves as the busy indication. Back-pressure is plain: a source may hold `req_valid` with stable `req_data` and `req_hold` until it sees `req_ready`. While `req_ready` is low, the request inputs are ignored. The lane outputs (`line_out`, `line_oe`) are meant for tri-state pad cells.

Top module: `shared_line_driver`

## Requirements
- R1: While `rst_n` is low and after its release, `line_oe` is 0, `req_ready` is 1 and `line_out` equals the idle value (parameter `IDLE_VAL`, default all zeros).
- R2: A request accepted on a rising edge (`req_valid` and `req_ready` both high) makes `line_oe` 1 and `line_out` equal to the accepted `req_data` from that edge on.
- R3: The requested value stays on the lanes with `line_oe` high for exactly `req_hold` clocks, where `req_hold` is taken as an unsigned count.
- R4: A `req_hold` of zero gives exactly one driving clock, the same as a count of one.
- R5: In the clock after the last driving clock, `line_oe` stays 1 and `line_out` equals the idle value for exactly one clock.
- R6: In the clock after that idle-drive clock, `line_oe` is 0 and `req_ready` is 1.
- R7: `req_ready` is 0 from the accepting edge until release. A `req_valid` pulse in that time changes neither the driven value nor the burst length, and it does not start a second burst.
- R8: Whenever `line_oe` is 0, `line_out` equals the idle value.
- R9: If `req_valid` stays high, the next request is taken on the first edge after release. Two bursts are therefore separated by exactly one released clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Lanes released; request can be taken (low = busy) |
| req_data | input | LANES | Value to drive during the burst |
| req_hold | input | CNT_W | Number of driving clocks (0 treated as 1) |
| line_out | output | LANES | Lane output value for tri-state pads |
| line_oe | output | 1 | Lane output enable |

## Verification
A wrong internal state shows at the ports in the same clock, because `line_oe`, `line_out` and `req_ready` decode the registered sequencer state directly. A hold counter that is off by one moves the idle-drive clock a cycle early or late. A skipped restore shows up as `line_oe` falling while a non-idle value is still on the lanes. A stray acceptance while busy shows as a changed value or an extra burst within the next few clocks. For these reasons, every clock of each burst and the two clocks after it are compared against values computed from the request.

// File: rtl/sld_pkg.sv
package sld_pkg;
  typedef enum logic [1:0] {
    SLD_RELEASED = 2'd0,
    SLD_DRIVE    = 2'd1,
    SLD_RESTORE  = 2'd2
  } sld_state_e;
endpackage

// File: rtl/sld_hold_ctr.sv
module sld_hold_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             at_zero
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    remain_q <= '0;
    else if (load) remain_q <= load_val;
    else if (dec)  remain_q <= remain_q - 1'b1;
  end

  assign at_zero = (remain_q == '0);
endmodule

// File: rtl/sld_seq.sv
module sld_seq
  import sld_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       cnt_zero,
  output sld_state_e state,
  output logic       accept
);
  sld_state_e state_q, state_d;

  assign accept = req_valid && (state_q == SLD_RELEASED);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SLD_RELEASED: if (accept)   state_d = SLD_DRIVE;
      SLD_DRIVE:    if (cnt_zero) state_d = SLD_RESTORE;
      SLD_RESTORE:                state_d = SLD_RELEASED;
      default:                    state_d = SLD_RELEASED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SLD_RELEASED;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/sld_lane_drive.sv
module sld_lane_drive #(
  parameter int               LANES    = 4,
  parameter logic [LANES-1:0] IDLE_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LANES-1:0] data_in,
  input  logic             show_data,
  input  logic             enable,
  output logic [LANES-1:0] lane_val,
  output logic             lane_oe
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic held_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held_q <= IDLE_VAL[i];
      else if (load) held_q <= data_in[i];
    end
    assign lane_val[i] = show_data ? held_q : IDLE_VAL[i];
  end

  assign lane_oe = enable;
endmodule

// File: rtl/shared_line_driver.sv
module shared_line_driver
  import sld_pkg::*;
#(
  parameter int               LANES    = 4,
  parameter int               CNT_W    = 4,
  parameter logic [LANES-1:0] IDLE_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LANES-1:0] req_data,
  input  logic [CNT_W-1:0] req_hold,
  output logic [LANES-1:0] line_out,
  output logic             line_oe
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  sld_state_e       state;
  logic             accept;
  logic             cnt_zero;
  logic [CNT_W-1:0] first_val;

  // A count of zero runs as a single driving clock.
  assign first_val = (req_hold == '0) ? '0 : req_hold - ONE;

  sld_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .cnt_zero  (cnt_zero),
    .state     (state),
    .accept    (accept)
  );

  sld_hold_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (first_val),
    .dec      ((state == SLD_DRIVE) && !cnt_zero),
    .at_zero  (cnt_zero)
  );

  sld_lane_drive #(.LANES(LANES), .IDLE_VAL(IDLE_VAL)) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .data_in   (req_data),
    .show_data (state == SLD_DRIVE),
    .enable    (state != SLD_RELEASED),
    .lane_val  (line_out),
    .lane_oe   (line_oe)
  );

  assign req_ready = (state == SLD_RELEASED);
endmodule

// File: rtl/shared_line_driver_chk.sv
module shared_line_driver_chk #(
  parameter int               LANES    = 4,
  parameter int               CNT_W    = 4,
  parameter logic [LANES-1:0] IDLE_VAL = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LANES-1:0] req_data,
  input logic [CNT_W-1:0] req_hold,
  input logic [LANES-1:0] line_out,
  input logic             line_oe
);
  logic [CNT_W:0] burst_left;
  logic           in_burst;

  // Tracks the expected number of driving clocks per burst.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_left <= '0;
      in_burst   <= 1'b0;
    end else if (req_valid && req_ready) begin
      burst_left <= (req_hold == '0) ? (CNT_W+1)'(1) : {1'b0, req_hold};
      in_burst   <= 1'b1;
    end else if (in_burst) begin
      burst_left <= burst_left - 1'b1;
      if (burst_left == (CNT_W+1)'(1)) in_burst <= 1'b0;
    end
  end

  // R2
  take_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (line_oe && line_out == $past(req_data)));

  // R3
  burst_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst && !(req_valid && req_ready)) |-> (line_oe && !req_ready));

  // R5
  restore_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> ($past(line_out) == IDLE_VAL));

  // R7
  busy_while_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> !req_ready);

  // R8
  idle_when_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> (line_out == IDLE_VAL && req_ready));

  // R2
  start_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> $past(req_valid && req_ready));
endmodule

bind shared_line_driver shared_line_driver_chk #(
  .LANES(LANES), .CNT_W(CNT_W), .IDLE_VAL(IDLE_VAL)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_data(req_data), .req_hold(req_hold), .line_out(line_out), .line_oe(line_oe)
);

// File: tb/test_shared_line_driver.sv
module test_shared_line_driver;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int CNT_W = 4;
  localparam logic [LANES-1:0] IDLE = '0;
  localparam int NVEC = 6;
  localparam logic [LANES-1:0] VEC_DATA [NVEC] = '{4'hA, 4'h5, 4'hF, 4'h3, 4'h9, 4'h6};
  localparam logic [CNT_W-1:0] VEC_HOLD [NVEC] = '{4'd3, 4'd1, 4'd0, 4'd7, 4'd15, 4'd2};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [LANES-1:0] req_data = '0;
  logic [CNT_W-1:0] req_hold = '0;
  logic [LANES-1:0] line_out;
  logic             line_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_line_driver #(.LANES(LANES), .CNT_W(CNT_W), .IDLE_VAL(IDLE)) i_shared_line_driver (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .req_hold(req_hold), .line_out(line_out), .line_oe(line_oe)
  );

  task automatic expect_pins(string tag, logic oe, logic [LANES-1:0] val, logic rdy);
    checks++;
    if (line_oe !== oe || line_out !== val || req_ready !== rdy) begin
      errors++;
      $display("FAIL %s: oe/out/ready = %b/%h/%b, expected %b/%h/%b",
               tag, line_oe, line_out, req_ready, oe, val, rdy);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    expect_pins("R1 in reset", 1'b0, IDLE, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    expect_pins("R1 after reset", 1'b0, IDLE, 1'b1);

    // Vector walk: R2, R3, R4, R5, R6, R7
    for (int v = 0; v < NVEC; v++) begin
      int n;
      n = (VEC_HOLD[v] == 0) ? 1 : int'(VEC_HOLD[v]);
      req_valid = 1'b1;
      req_data  = VEC_DATA[v];
      req_hold  = VEC_HOLD[v];
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        expect_pins((VEC_HOLD[v] == 0) ? "R4 zero hold drive" : "R3 drive phase",
                    1'b1, VEC_DATA[v], 1'b0);
        if (k == 0 && n >= 2) begin
          // R7: stray request while busy must be ignored
          req_valid = 1'b1;
          req_data  = ~VEC_DATA[v];
          req_hold  = 4'd1;
        end else begin
          req_valid = 1'b0;
        end
      end
      req_valid = 1'b0;
      @(negedge clk);
      expect_pins("R5 idle drive", 1'b1, IDLE, 1'b0);
      @(negedge clk);
      expect_pins("R6 released", 1'b0, IDLE, 1'b1);
      @(negedge clk);
      expect_pins("R7 R8 no extra burst", 1'b0, IDLE, 1'b1);
    end

    // R9: back-to-back with valid held high
    req_valid = 1'b1;
    req_data  = 4'hC;
    req_hold  = 4'd1;
    @(negedge clk);
    expect_pins("R9 first burst", 1'b1, 4'hC, 1'b0);
    @(negedge clk);
    expect_pins("R9 restore", 1'b1, IDLE, 1'b0);
    @(negedge clk);
    expect_pins("R9 one released clock", 1'b0, IDLE, 1'b1);
    @(negedge clk);
    expect_pins("R9 second burst", 1'b1, 4'hC, 1'b0);
    req_valid = 1'b0;
    @(negedge clk);
    expect_pins("R9 second restore", 1'b1, IDLE, 1'b0);
    @(negedge clk);
    expect_pins("R8 released again", 1'b0, IDLE, 1'b1);

    // R1: reset in the middle of a burst
    req_valid = 1'b1;
    req_data  = 4'h7;
    req_hold  = 4'd5;
    @(negedge clk);
    req_valid = 1'b0;
    expect_pins("R2 burst before reset", 1'b1, 4'h7, 1'b0);
    rst_n = 1'b0;
    #1;
    expect_pins("R1 reset mid burst", 1'b0, IDLE, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_pins("R1 stays released", 1'b0, IDLE, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule